// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block forms the address of a memory operand from the parts of an addressing mode. It takes up to three offset terms: a base register value, an index register value shifted left by a scale amount, and a signed displacement that arrives as 8, 16 or 32 significant bits. A presence flag goes with each term, and a term whose flag is low contributes zero. The sum of the present terms is the offset within a segment. Adding the segment base to that offset gives the linear address. Both sums wrap modulo 2^ADDR_W.

A request is presented with a valid/ready handshake. Once a request is accepted, the offset and the linear address appear on registered outputs on the next cycle, and an output valid strobe is high for that one cycle. The registered values then hold until the next accepted request. A decoder upstream drives the presence flags, so every common operand form can be built from the same port set: displacement alone, base alone, base with displacement, scaled index with displacement, and base with scaled index and displacement.

Top module: `seg_addr_gen`

## Requirements
- R1: While `rstN` is low, `inReady`, `outValid`, `outOffset` and `outLinear` are all zero.
- R2: `inReady` is high from the first rising clock edge at which `rstN` is sampled high, and stays high after that. A request presented while `inReady` is low is not accepted.
- R3: `outValid` is high in the cycle after each accepted request (`inValid` and `inReady` both high at a rising edge) and low in every other cycle, including during back-to-back accepts separated by idle cycles.
- R4: `scaleSel` values 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8 (a left shift by `scaleSel`).
- R5: `dispSel` 0 sign-extends `dispVal[7:0]`, 1 sign-extends `dispVal[15:0]`, and 2 or 3 use all 32 bits. Displacement bits above the selected width are ignored.
- R6: When `hasBase`, `hasIndex` or `hasDisp` is low, the matching term contributes zero whatever its data input carries. With all three low, the offset is zero.
- R7: `outOffset` equals the sum of the present terms modulo 2^32.
- R8: `outLinear` equals `segBase` plus the offset modulo 2^32, using the `segBase` presented with the same request.
- R9: Without an accepted request, `outOffset` and `outLinear` keep their previous values.
- R10: A request with only the index present (no base, no displacement) yields the scaled index as its offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request valid |
| inReady | output | 1 | Block can accept a request |
| hasBase | input | 1 | Base term present |
| hasIndex | input | 1 | Index term present |
| hasDisp | input | 1 | Displacement term present |
| baseVal | input | ADDR_W | Base register value |
| indexVal | input | ADDR_W | Index register value |
| scaleSel | input | 2 | Index shift amount (factor 1, 2, 4, 8) |
| dispSel | input | 2 | Displacement width: 0 = 8, 1 = 16, 2/3 = 32 bits |
| dispVal | input | ADDR_W | Displacement bits |
| segBase | input | ADDR_W | Segment base address |
| outValid | output | 1 | Result valid strobe |
| outOffset | output | ADDR_W | Registered offset within the segment |
| outLinear | output | ADDR_W | Registered linear address |

## Verification
The bench builds the block with its default 32-bit address width and 2-bit scale field. With these values every shift amount, every displacement width code (including the spare code 3) and carries out of bit 31 in both adders can be reached with ordinary 32-bit stimulus. Values near the top of the range and sign bits at bits 7 and 15 are forced directly. Random traffic with random idle gaps and random presence flags covers the hold behaviour between results.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  // displacement width selector codes
  typedef enum logic [1:0] {
    DISP_BYTE     = 2'd0,
    DISP_HALF     = 2'd1,
    DISP_WORD     = 2'd2,
    DISP_WORD_ALT = 2'd3
  } dispWidth_e;

  // number of distinct displacement widths
  localparam int NUM_DISP_W = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture a new result
    logic validSet; // raise output valid next cycle
  } ctrlStrobe_t;

  // significant bits for displacement width number g
  function automatic int dispBits(input int g);
    return 8 << g;
  endfunction

endpackage

// File: rtl/seg_addr_ctrl.sv
module seg_addr_ctrl
  import seg_addr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  output logic        outValid,
  output ctrlStrobe_t strobe
);

  logic readyQ;
  logic validQ;

  // ready rises after the first edge out of reset
  always_ff @(posedge clk) begin
    if (!rstN) readyQ <= 1'b0;
    else       readyQ <= 1'b1;
  end

  always_comb begin
    strobe.load     = inValid && readyQ;
    strobe.validSet = inValid && readyQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= strobe.validSet;
  end

  assign inReady  = readyQ;
  assign outValid = validQ;

endmodule

// File: rtl/seg_addr_dp.sv
module seg_addr_dp
  import seg_addr_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SCALE_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic               hasBase,
  input  logic               hasIndex,
  input  logic               hasDisp,
  input  logic [ADDR_W-1:0]  baseVal,
  input  logic [ADDR_W-1:0]  indexVal,
  input  logic [SCALE_W-1:0] scaleSel,
  input  logic [1:0]         dispSel,
  input  logic [ADDR_W-1:0]  dispVal,
  input  logic [ADDR_W-1:0]  segBase,
  output logic [ADDR_W-1:0]  outOffset,
  output logic [ADDR_W-1:0]  outLinear
);

  localparam int NUM_SCALE = 1 << SCALE_W;

  logic [ADDR_W-1:0] extCand   [NUM_DISP_W];
  logic [ADDR_W-1:0] scaleCand [NUM_SCALE];

  // one sign extender per supported displacement width
  for (genvar g = 0; g < NUM_DISP_W; g++) begin : gDispExt
    localparam int W = dispBits(g);
    if (W < ADDR_W) begin : gNarrow
      assign extCand[g] = {{(ADDR_W - W){dispVal[W-1]}}, dispVal[W-1:0]};
    end else begin : gFull
      assign extCand[g] = dispVal;
    end
  end

  // one shifted copy of the index per scale code
  for (genvar s = 0; s < NUM_SCALE; s++) begin : gScale
    assign scaleCand[s] = indexVal << s;
  end

  logic [ADDR_W-1:0] baseTerm;
  logic [ADDR_W-1:0] indexTerm;
  logic [ADDR_W-1:0] dispTerm;
  logic [ADDR_W-1:0] offsetSum;
  logic [ADDR_W-1:0] linearSum;
  logic [1:0]        dispPick;

  always_comb begin
    dispPick  = (dispSel == DISP_WORD_ALT) ? 2'(DISP_WORD) : dispSel;
    baseTerm  = hasBase  ? baseVal             : '0;
    indexTerm = hasIndex ? scaleCand[scaleSel] : '0;
    dispTerm  = hasDisp  ? extCand[dispPick]   : '0;
    offsetSum = baseTerm + indexTerm + dispTerm;
    linearSum = segBase + offsetSum;
  end

  logic [ADDR_W-1:0] offsetQ;
  logic [ADDR_W-1:0] linearQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offsetQ <= '0;
      linearQ <= '0;
    end else if (strobe.load) begin
      offsetQ <= offsetSum;
      linearQ <= linearSum;
    end
  end

  assign outOffset = offsetQ;
  assign outLinear = linearQ;

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic              hasBase,
  input  logic              hasIndex,
  input  logic              hasDisp,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] indexVal,
  input  logic [1:0]        scaleSel,
  input  logic [1:0]        dispSel,
  input  logic [ADDR_W-1:0] dispVal,
  input  logic [ADDR_W-1:0] segBase,
  output logic              outValid,
  output logic [ADDR_W-1:0] outOffset,
  output logic [ADDR_W-1:0] outLinear
);

  ctrlStrobe_t strobe;

  seg_addr_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  seg_addr_dp #(.ADDR_W(ADDR_W), .SCALE_W(2)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .hasBase   (hasBase),
    .hasIndex  (hasIndex),
    .hasDisp   (hasDisp),
    .baseVal   (baseVal),
    .indexVal  (indexVal),
    .scaleSel  (scaleSel),
    .dispSel   (dispSel),
    .dispVal   (dispVal),
    .segBase   (segBase),
    .outOffset (outOffset),
    .outLinear (outLinear)
  );

endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              hasBase,
  input logic              hasIndex,
  input logic              hasDisp,
  input logic [ADDR_W-1:0] segBase,
  input logic              outValid,
  input logic [ADDR_W-1:0] outOffset,
  input logic [ADDR_W-1:0] outLinear
);

  a_r2_ready_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> inReady);

  a_r3_valid_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  a_r3_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inReady) |=> !outValid);

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inReady) |=> ($stable(outOffset) && $stable(outLinear)));

  a_r8_linear_relation: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> ((outLinear - outOffset) == $past(segBase)));

  a_r6_all_absent_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !hasBase && !hasIndex && !hasDisp) |=> (outOffset == '0));

endmodule

bind seg_addr_gen seg_addr_chk #(.ADDR_W(ADDR_W)) uChk (.*);

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic          hasBase = 1'b0, hasIndex = 1'b0, hasDisp = 1'b0;
  logic [AW-1:0] baseVal = '0, indexVal = '0, dispVal = '0, segBase = '0;
  logic [1:0]    scaleSel = '0, dispSel = '0;
  logic          outValid;
  logic [AW-1:0] outOffset, outLinear;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  seg_addr_gen #(.ADDR_W(AW)) u0 (.*);

  function automatic logic [31:0] extDisp(input logic [31:0] d, input logic [1:0] sel);
    case (sel)
      2'd0:    return {{24{d[7]}}, d[7:0]};
      2'd1:    return {{16{d[15]}}, d[15:0]};
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] refOffset(input bit hb, input bit hi, input bit hd,
      input logic [31:0] b, input logic [31:0] x, input logic [1:0] sc,
      input logic [31:0] d, input logic [1:0] ds);
    logic [31:0] acc;
    acc = 32'd0;
    if (hb) acc = acc + b;
    if (hi) acc = acc + (x * (32'd1 << sc));
    if (hd) acc = acc + extDisp(d, ds);
    return acc;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // pending expectation from the previous cycle
  bit          pend = 0;
  string       pendTag = "R7";
  logic [31:0] expOff = '0, expLin = '0;

  // call at a negedge: checks outputs, then drives a new request (or idle)
  task automatic step(input bit v, input string tag, input bit hb, input bit hi,
      input bit hd, input logic [31:0] b, input logic [31:0] x, input logic [1:0] sc,
      input logic [31:0] d, input logic [1:0] ds, input logic [31:0] sg);
    check("R3 outValid", {31'd0, outValid}, {31'd0, pend});
    if (pend) begin
      check({pendTag, " offset"}, outOffset, expOff);
      check("R8 linear", outLinear, expLin);
    end else begin
      check("R9 offset hold", outOffset, expOff);
      check("R9 linear hold", outLinear, expLin);
    end
    inValid = v; hasBase = hb; hasIndex = hi; hasDisp = hd;
    baseVal = b; indexVal = x; scaleSel = sc; dispVal = d; dispSel = ds; segBase = sg;
    pend = v && inReady;
    if (pend) begin
      pendTag = tag;
      expOff = refOffset(hb, hi, hd, b, x, sc, d, ds);
      expLin = sg + expOff;
    end
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 inReady", {31'd0, inReady}, 32'd0);
    check("R1 outValid", {31'd0, outValid}, 32'd0);
    check("R1 offset", outOffset, 32'd0);
    check("R1 linear", outLinear, 32'd0);

    // R2: release reset with a request already present; it must not be taken
    rstN = 1'b1;
    inValid = 1'b1; hasBase = 1'b1; baseVal = 32'h1111_0000; segBase = 32'h0000_0100;
    @(negedge clk);
    check("R2 ready up", {31'd0, inReady}, 32'd1);
    check("R2 not accepted", {31'd0, outValid}, 32'd0);
    inValid = 1'b0;
    pend = 0; expOff = '0; expLin = '0;

    // directed corner cases
    step(1, "R5 byte", 0, 0, 1, 32'h0, 32'h0, 2'd0, 32'h1234_5680, 2'd0, 32'h0000_1000);
    step(1, "R5 half", 1, 0, 1, 32'h0000_0010, 32'h0, 2'd0, 32'hABCD_8000, 2'd1, 32'h0);
    step(1, "R5 word alt", 0, 0, 1, 32'h0, 32'h0, 2'd0, 32'h8000_0001, 2'd3, 32'h10);
    step(0, "R9", 1, 1, 1, 32'hFFFF_FFFF, 32'h5, 2'd3, 32'h7, 2'd2, 32'h55);
    step(0, "R9", 0, 0, 0, 32'h0, 32'h0, 2'd0, 32'h0, 2'd0, 32'h0);
    for (int s = 0; s < 4; s++)
      step(1, "R4 scale", 0, 1, 0, 32'h0, 32'h2000_0003, 2'(s), 32'h0, 2'd0, 32'h0);
    step(1, "R10 index only", 0, 1, 0, 32'hDEAD_BEEF, 32'h0000_0040, 2'd2, 32'hCAFE_F00D, 2'd2, 32'h0);
    step(1, "R6 all absent", 0, 0, 0, 32'h1234_5678, 32'h9ABC_DEF0, 2'd3, 32'h0F0F_0F0F, 2'd2, 32'h0000_0200);
    step(1, "R7 wrap", 1, 1, 1, 32'hFFFF_FFF0, 32'h8000_0001, 2'd1, 32'h0000_00FF, 2'd0, 32'hFFFF_FF00);
    step(1, "R8 seg wrap", 1, 0, 0, 32'h8000_0000, 32'h0, 2'd0, 32'h0, 2'd0, 32'h9000_0000);

    // random traffic with gaps
    for (int i = 0; i < 600; i++) begin
      step(($urandom % 4) != 0, "R7 random",
           $urandom % 2, $urandom % 2, $urandom % 2,
           $urandom, $urandom, 2'($urandom), $urandom, 2'($urandom), $urandom);
    end
    step(0, "R9", 0, 0, 0, 32'h0, 32'h0, 2'd0, 32'h0, 2'd0, 32'h0);
    step(0, "R9", 0, 0, 0, 32'h0, 32'h0, 2'd0, 32'h0, 2'd0, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule